// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator and Interrupt Flag Register

This block sits beside the time-keeping counters of a real-time clock. It holds three alarm bytes (seconds, minutes, hours). It compares them against the live time fields only when the counters report that an update has completed. A match raises the alarm flag. The update-complete event raises its own flag, and an external periodic tick raises a third.

Each flag is gated by its own enable. The OR of the gated flags drives both the interrupt line and the top bit of the status byte. Software reads the status byte with a one-cycle strobe. The byte shows the pending flags during that cycle, and every flag is cleared by the next cycle.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A single-cycle write into an alarm byte always completes.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `stat_q` reads 0x00 and `irq` is low. All three alarm bytes reset to 0x00.
- R2: A cycle with `upd_done` high sets the update flag, `stat_q` bit 4, from the next cycle on.
- R3: On `upd_done`, the alarm flag (`stat_q` bit 5) is set when the seconds, minutes and hours alarm bytes each equal their live time field. If any byte differs, the flag is not set.
- R4: An alarm byte whose bits 7 and 6 are both 1 (0xC0 to 0xFF) matches any value of its field. A byte with only one of those two bits set compares as an ordinary value.
- R5: The hours comparison covers all eight bits, including the PM bit 7. An alarm of 0x82 does not match an hour of 0x02, and an alarm of 0x02 does not match an hour of 0x82.
- R6: The alarm is evaluated only in a cycle with `upd_done` high. A matching time held without that pulse leaves the alarm flag clear.
- R7: A cycle with `per_tick` high sets the periodic flag, `stat_q` bit 6, from the next cycle on.
- R8: `irq` and `stat_q` bit 7 equal (PF and `en_per`) or (AF and `en_alm`) or (UF and `en_upd`). They follow a change of an enable in the same cycle. `stat_q` bits 3:0 are always 0.
- R9: A cycle with `stat_rd` high presents the pending flags on `stat_q`. From the next cycle, all flags are clear and `irq` is low, so a second read returns 0x00.
- R10: A flag whose set event arrives in the same cycle as `stat_rd` is still set after that read.
- R11: `alm_wr_en` writes `alm_wr_data` into the alarm byte selected by `alm_wr_sel` (0 seconds, 1 minutes, 2 hours). Select value 3 changes no alarm byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_sec | input | 8 | Live seconds field |
| time_min | input | 8 | Live minutes field |
| time_hour | input | 8 | Live hours field, bit 7 is PM in 12-hour mode |
| alm_wr_en | input | 1 | Alarm byte write strobe |
| alm_wr_sel | input | 2 | Alarm byte select: 0 seconds, 1 minutes, 2 hours |
| alm_wr_data | input | 8 | Alarm byte value |
| en_per | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update interrupt enable |
| upd_done | input | 1 | One-cycle pulse at the end of an update |
| per_tick | input | 1 | One-cycle periodic tick |
| stat_rd | input | 1 | Status read strobe; clears all flags |
| stat_q | output | 8 | Status byte {IRQF, PF, AF, UF, 4'b0} |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench aims at three kinds of fault.

The first is the wildcard boundary. Alarm bytes 0x80 and 0x40 must not act as wildcards. A design that tested only one of the top bits would fire on them.

The second is the hours byte in PM. A 0x82 alarm against a 0x02 hour, and the reverse, catches a comparator that masks bit 7.

The third is timing. A matching time held without an update pulse catches a design that compares every cycle. A tick arriving during a status read catches a clear that swallows a new event. Toggling an enable while a flag is pending catches an IRQ that is only recomputed on flag events.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 3;
  localparam int SEL_W      = $clog2(NUM_FIELDS + 1);
  localparam int NUM_FLAGS  = 3;
  localparam int STAT_W     = 8;

  // Bit positions in the status byte; software decodes these.
  localparam int POS_IRQF = 7;
  localparam int POS_PF   = 6;
  localparam int POS_AF   = 5;
  localparam int POS_UF   = 4;

  // Index of each flag inside the packed flag vector.
  typedef enum logic [1:0] {
    FLG_UF = 2'd0,
    FLG_AF = 2'd1,
    FLG_PF = 2'd2
  } flag_idx_e;
endpackage

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank #(
  parameter int FW = 8,
  parameter int NF = 3,
  parameter int SW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SW-1:0]         wr_sel,
  input  logic [FW-1:0]         wr_data,
  input  logic [NF-1:0][FW-1:0] now,
  output logic                  hit
);
  localparam logic [1:0] WILD = 2'b11;

  logic [NF-1:0][FW-1:0] alarm_q;
  logic [NF-1:0]         field_hit;

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alarm_q[i] <= '0;
      end else if (wr_en && (wr_sel == SW'(i))) begin
        alarm_q[i] <= wr_data;
      end
    end

    // A byte with both top bits set is a don't-care; otherwise all bits compare.
    always_comb begin
      field_hit[i] = (alarm_q[i][FW-1 -: 2] == WILD) || (alarm_q[i] == now[i]);
    end
  end

  assign hit = &field_hit;
endmodule

// File: rtl/rtc_flag_bit.sv
module rtc_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // A set arriving with the clear wins, so no event is lost on a read.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/rtc_irq_merge.sv
module rtc_irq_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         any
);
  assign any = |(flags & enables);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] time_sec,
  input  logic [FIELD_W-1:0] time_min,
  input  logic [FIELD_W-1:0] time_hour,
  input  logic               alm_wr_en,
  input  logic [SEL_W-1:0]   alm_wr_sel,
  input  logic [FIELD_W-1:0] alm_wr_data,
  input  logic               en_per,
  input  logic               en_alm,
  input  logic               en_upd,
  input  logic               upd_done,
  input  logic               per_tick,
  input  logic               stat_rd,
  output logic [STAT_W-1:0]  stat_q,
  output logic               irq
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_fields;
  logic                               alarm_hit;
  logic [NUM_FLAGS-1:0]               flag_set;
  logic [NUM_FLAGS-1:0]               flag_q;
  logic [NUM_FLAGS-1:0]               flag_en;

  // Field order matches the write select: seconds, minutes, hours.
  assign now_fields = {time_hour, time_min, time_sec};

  rtc_alarm_bank #(
    .FW (FIELD_W),
    .NF (NUM_FIELDS),
    .SW (SEL_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (alm_wr_en),
    .wr_sel  (alm_wr_sel),
    .wr_data (alm_wr_data),
    .now     (now_fields),
    .hit     (alarm_hit)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FLG_UF] = upd_done;
    flag_set[FLG_AF] = upd_done & alarm_hit;
    flag_set[FLG_PF] = per_tick;
    flag_en          = '0;
    flag_en[FLG_UF]  = en_upd;
    flag_en[FLG_AF]  = en_alm;
    flag_en[FLG_PF]  = en_per;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    rtc_flag_bit u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[f]),
      .clr   (stat_rd),
      .q     (flag_q[f])
    );
  end

  rtc_irq_merge #(.N(NUM_FLAGS)) u_merge (
    .flags   (flag_q),
    .enables (flag_en),
    .any     (irq)
  );

  always_comb begin
    stat_q           = '0;
    stat_q[POS_IRQF] = irq;
    stat_q[POS_PF]   = flag_q[FLG_PF];
    stat_q[POS_AF]   = flag_q[FLG_AF];
    stat_q[POS_UF]   = flag_q[FLG_UF];
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_per,
  input logic       en_alm,
  input logic       en_upd,
  input logic       upd_done,
  input logic       per_tick,
  input logic       stat_rd,
  input logic [7:0] stat_q,
  input logic       irq
);
  // R2
  upd_sets_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> stat_q[4]);

  // R7
  tick_sets_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> stat_q[6]);

  // R6
  af_only_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[5]) |-> $past(upd_done));

  // R8
  irq_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((stat_q[6] & en_per) | (stat_q[5] & en_alm) | (stat_q[4] & en_upd)));

  // R8
  irqf_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[7] == irq) && (stat_q[3:0] == 4'h0));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !upd_done && !per_tick) |=> (stat_q[6:4] == 3'b000) && !irq);

  // R10
  read_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && per_tick) |=> stat_q[6]);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_per   (en_per),
  .en_alm   (en_alm),
  .en_upd   (en_upd),
  .upd_done (upd_done),
  .per_tick (per_tick),
  .stat_rd  (stat_rd),
  .stat_q   (stat_q),
  .irq      (irq)
);

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] time_sec = '0, time_min = '0, time_hour = '0;
  logic       alm_wr_en = 1'b0;
  logic [1:0] alm_wr_sel = '0;
  logic [7:0] alm_wr_data = '0;
  logic       en_per = 1'b0, en_alm = 1'b0, en_upd = 1'b0;
  logic       upd_done = 1'b0, per_tick = 1'b0, stat_rd = 1'b0;
  logic [7:0] stat_q;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .time_sec(time_sec), .time_min(time_min), .time_hour(time_hour),
    .alm_wr_en(alm_wr_en), .alm_wr_sel(alm_wr_sel), .alm_wr_data(alm_wr_data),
    .en_per(en_per), .en_alm(en_alm), .en_upd(en_upd),
    .upd_done(upd_done), .per_tick(per_tick), .stat_rd(stat_rd),
    .stat_q(stat_q), .irq(irq)
  );

  // {sec, min, hour, alarm sec, alarm min, alarm hour, expected alarm}
  localparam int NV = 9;
  localparam logic [48:0] VEC [NV] = '{
    {8'h30, 8'h15, 8'h09, 8'h30, 8'h15, 8'h09, 1'b1},
    {8'h30, 8'h15, 8'h09, 8'h31, 8'h15, 8'h09, 1'b0},
    {8'h30, 8'h15, 8'h09, 8'hC0, 8'hC0, 8'h09, 1'b1},
    {8'h59, 8'h59, 8'h23, 8'hFF, 8'hC5, 8'hC0, 1'b1},
    {8'h00, 8'h00, 8'h82, 8'hC0, 8'hC0, 8'h82, 1'b1},
    {8'h00, 8'h00, 8'h82, 8'hC0, 8'hC0, 8'h02, 1'b0},
    {8'h00, 8'h00, 8'h02, 8'hC0, 8'hC0, 8'h82, 1'b0},
    {8'h10, 8'h20, 8'h05, 8'h80, 8'h20, 8'h05, 1'b0},
    {8'h10, 8'h20, 8'h05, 8'h40, 8'h20, 8'h05, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_alarm(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); alm_wr_en = 1'b1; alm_wr_sel = sel; alm_wr_data = d;
    @(negedge clk); alm_wr_en = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_done = 1'b1;
    @(negedge clk); upd_done = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
  endtask

  task automatic read_stat(output logic [7:0] v);
    @(negedge clk); stat_rd = 1'b1;
    #1 v = stat_q;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 stat", stat_q, 8'h00);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stat after release", stat_q, 8'h00);

    // R3 R4 R5 table walk; each update also raises UF (R2)
    for (int i = 0; i < NV; i++) begin
      time_sec = VEC[i][48:41]; time_min = VEC[i][40:33]; time_hour = VEC[i][32:25];
      wr_alarm(2'd0, VEC[i][24:17]);
      wr_alarm(2'd1, VEC[i][16:9]);
      wr_alarm(2'd2, VEC[i][8:1]);
      read_stat(v);
      pulse_upd();
      check($sformatf("R3 R4 R5 vector %0d AF", i), stat_q[5], VEC[i][0]);
      check($sformatf("R2 vector %0d UF", i), stat_q[4], 1);
      read_stat(v);
    end

    // R6: matching time, no update pulse
    time_sec = 8'h11; time_min = 8'h22; time_hour = 8'h03;
    wr_alarm(2'd0, 8'h11); wr_alarm(2'd1, 8'h22); wr_alarm(2'd2, 8'h03);
    read_stat(v);
    repeat (5) @(negedge clk);
    check("R6 no AF without update", stat_q, 8'h00);

    // R11: select 3 leaves the alarm bytes alone
    wr_alarm(2'd3, 8'h00);
    pulse_upd();
    check("R11 sel3 no effect", stat_q[5], 1);
    // R8: enable toggling drives irq and IRQF at once
    check("R8 irq off", irq, 0);
    @(negedge clk); en_alm = 1'b1; #1;
    check("R8 irq on enable", irq, 1);
    check("R8 IRQF", stat_q[7], 1);
    @(negedge clk); en_alm = 1'b0; #1;
    check("R8 irq off again", irq, 0);
    @(negedge clk); en_upd = 1'b1; #1;
    check("R8 irq via UF", irq, 1);

    // R9: read returns flags, second read zero
    read_stat(v);
    check("R9 first read", v, 8'hB0);
    #1 check("R9 irq released", irq, 0);
    read_stat(v);
    check("R9 second read", v, 8'h00);
    en_upd = 1'b0;

    // R7: periodic tick
    pulse_tick();
    check("R7 PF", stat_q, 8'h40);
    @(negedge clk); en_per = 1'b1; #1;
    check("R8 irq via PF", irq, 1);

    // R10: tick during read survives
    @(negedge clk); stat_rd = 1'b1; per_tick = 1'b1;
    @(negedge clk); stat_rd = 1'b0; per_tick = 1'b0;
    check("R10 PF kept", stat_q, 8'hC0);
    read_stat(v);
    check("R9 cleared", stat_q, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule